// File: doc/BRIEF.md
# Miss Buffer Allocator with Blocking

This block keeps track of outstanding memory transactions in two small pools of entries. Pool 0 holds miss-status entries, which cover cacheable read misses and uncacheable reads. Pool 1 is a write buffer for writes. Each allocation request carries a kind, an address, a byte size, a ready time and a flag that asks for the memory-side bus. The block grants a slot in the same cycle and stamps the entry with a rising order number. A mark-in-service request hands an entry downstream, frees its slot, and reports what the entry held.

The block keeps a three-bit mask of the reasons it is blocked. Bit 0 means the miss-status pool is full, bit 1 means the write buffer is full, and bit 2 means an external target limit was hit. The stall toward the processor is high whenever the mask is nonzero. While the block is stalled it counts cycles. When the mask empties, the elapsed stall cycles are added to the counter of the cause whose clearing emptied it. The block also reports the earliest ready time over all occupied entries of both pools. A loadable miss counter flags the moment a preset number of misses has been taken.

Top module: `mab_alloc_top`

## Requirements
- R1: `req_kind` encodes 0 = cacheable read miss and 1 = uncacheable read, both of which go to pool 0, and 2 = write, which goes to pool 1. Kind 3 is ignored: no grant, no order step, no bus request and no change to any pool.
- R2: A granted cacheable miss reports and stores its address rounded down to a multiple of `BLK_BYTES`, with a length of `BLK_BYTES`.
- R3: A granted uncacheable read or write reports and stores the request address and `req_size` unchanged.
- R4: Each granted allocation is stamped with `alloc_order`, which starts at 0 after reset and rises by one per grant. Marking the entry returns the same stamp, address and length on `svc_order`, `svc_addr` and `svc_len`.
- R5: A grant takes the lowest-numbered free slot of the selected pool. A full pool refuses requests, except when a mark on that pool in the same cycle frees a slot; the mark is applied first and its slot becomes available.
- R6: A pool's cause bit (bit 0 = pool 0, bit 1 = pool 1 of `blk_mask`) becomes set at the clock edge after an allocation that leaves the pool full.
- R7: A pool's cause bit clears only when a mark hits a valid entry of a pool that was full before the mark, unless an allocation in the same cycle refills the pool. A mark of a free slot does nothing.
- R8: `stall` is high exactly when `blk_mask` is nonzero.
- R9: When `blk_mask` returns to zero, the number of cycles it was nonzero is added to the 16-bit counter in `blk_cycles` of the lowest-numbered cause cleared in that edge. Cause c occupies bits [16c+15:16c].
- R10: A grant with `req_bus` set pulses bit `alloc_pool` of `bus_req` for one cycle, in the cycle after the grant.
- R11: `next_ready` is the minimum `req_ready_at` over all occupied entries of both pools, or all ones when both pools are empty.
- R12: `miss_load` loads `miss_load_val` into the miss counter. Each granted kind-0 or kind-1 request decrements a nonzero counter. `miss_limit_hit` pulses for one cycle after the decrement that reaches zero.
- R13: `tgt_block` sets mask bit 2 and `tgt_unblock` clears it; if both are high in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Allocation request |
| req_kind | input | 2 | Request kind, encoded as in R1 |
| req_addr | input | AW | Request byte address |
| req_size | input | LW | Request byte size |
| req_bus | input | 1 | Ask for the memory-side bus |
| req_ready_at | input | TW | Ready time stored with the entry |
| alloc_ok | output | 1 | Request granted this cycle |
| alloc_pool | output | 1 | Pool selected by the kind |
| alloc_slot | output | SLOTW | Slot granted |
| alloc_addr | output | AW | Address stored |
| alloc_len | output | LW | Length stored |
| alloc_order | output | OW | Order stamp of this grant |
| svc_valid | input | 1 | Mark-in-service request |
| svc_pool | input | 1 | Pool to mark |
| svc_slot | input | SLOTW | Slot to mark |
| svc_hit | output | 1 | The marked slot held an entry |
| svc_addr | output | AW | Address of the marked entry |
| svc_len | output | LW | Length of the marked entry |
| svc_order | output | OW | Order stamp of the marked entry |
| tgt_block | input | 1 | Set the target-limit cause |
| tgt_unblock | input | 1 | Clear the target-limit cause |
| stall | output | 1 | Processor-side stall |
| blk_mask | output | 3 | Blocked-cause mask |
| blk_cycles | output | 3*CW | Per-cause blocked-cycle counters |
| bus_req | output | 2 | Memory-side bus request pulse per pool |
| next_ready | output | TW | Earliest ready time |
| miss_load | input | 1 | Load the miss counter |
| miss_load_val | input | MW | Value to load |
| miss_limit_hit | output | 1 | Miss counter reached zero |

## Verification
The hardest case to reach is a full pool that receives a mark and an allocation in the same cycle. Here the mark must be applied first, the grant must land in the slot just freed, and the cause bit must stay set with no charge to the cycle counters. A uniform random mix rarely fills a pool and then lines up both requests on it. The stimulus therefore fills each pool with directed sequences before issuing the combined request. Random traffic is weighted toward allocation over marking, so that pools are often full and the full-to-not-full transitions happen often.

// File: rtl/mab_pkg.sv
package mab_pkg;
  typedef enum logic [1:0] {
    KIND_CMISS = 2'd0,
    KIND_UREAD = 2'd1,
    KIND_WRITE = 2'd2,
    KIND_BAD   = 2'd3
  } req_kind_e;

  localparam int NUM_POOL  = 2;
  localparam int NUM_CAUSE = 3;
  localparam int CAUSE_TGT = 2;

  function automatic logic kind_to_pool(input logic [1:0] k);
    return k == KIND_WRITE;
  endfunction

  function automatic logic kind_legal(input logic [1:0] k);
    return k != KIND_BAD;
  endfunction

  function automatic logic kind_is_miss(input logic [1:0] k);
    return (k == KIND_CMISS) || (k == KIND_UREAD);
  endfunction
endpackage

// File: rtl/mab_pool.sv
module mab_pool #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int LW    = 8,
  parameter int TW    = 16,
  parameter int OW    = 16,
  parameter int SLOTW = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_fire,
  input  logic [AW-1:0]    alloc_addr,
  input  logic [LW-1:0]    alloc_len,
  input  logic [TW-1:0]    alloc_ready,
  input  logic [OW-1:0]    alloc_order,
  input  logic             mark_req,
  input  logic [SLOTW-1:0] mark_slot,
  output logic             can_alloc,
  output logic [SLOTW-1:0] free_slot,
  output logic             mark_hit,
  output logic [AW-1:0]    mark_addr,
  output logic [LW-1:0]    mark_len,
  output logic [OW-1:0]    mark_order,
  output logic [TW-1:0]    earliest,
  output logic             is_full,
  output logic             ev_set,
  output logic             ev_clr
);
  logic [DEPTH-1:0] vld, kill, after_mark, pick, after_alloc;
  logic [AW-1:0] e_addr  [DEPTH];
  logic [LW-1:0] e_len   [DEPTH];
  logic [OW-1:0] e_order [DEPTH];
  logic [TW-1:0] e_ready [DEPTH];

  // Mark is applied before allocation: its slot is reusable this cycle.
  always_comb begin
    kill = '0;
    for (int i = 0; i < DEPTH; i++)
      if (mark_req && mark_slot == SLOTW'(i)) kill[i] = vld[i];
    mark_hit   = |kill;
    after_mark = vld & ~kill;
  end

  always_comb begin
    pick      = '0;
    free_slot = '0;
    for (int i = DEPTH-1; i >= 0; i--)
      if (!after_mark[i]) begin
        pick      = '0;
        pick[i]   = 1'b1;
        free_slot = SLOTW'(i);
      end
    can_alloc   = ~&after_mark;
    after_alloc = after_mark | (alloc_fire ? pick : '0);
  end

  assign is_full = &vld;
  assign ev_clr  = is_full && mark_hit;
  assign ev_set  = alloc_fire && (&after_alloc);

  always_comb begin
    mark_addr  = '0;
    mark_len   = '0;
    mark_order = '0;
    for (int i = 0; i < DEPTH; i++)
      if (kill[i]) begin
        mark_addr  = e_addr[i];
        mark_len   = e_len[i];
        mark_order = e_order[i];
      end
  end

  always_comb begin
    earliest = '1;
    for (int i = 0; i < DEPTH; i++)
      if (vld[i] && e_ready[i] < earliest) earliest = e_ready[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) vld <= '0;
    else        vld <= after_alloc;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        e_addr[g]  <= '0;
        e_len[g]   <= '0;
        e_order[g] <= '0;
        e_ready[g] <= '0;
      end else if (alloc_fire && pick[g]) begin
        e_addr[g]  <= alloc_addr;
        e_len[g]   <= alloc_len;
        e_order[g] <= alloc_order;
        e_ready[g] <= alloc_ready;
      end
    end
  end
endmodule

// File: rtl/mab_block_ctrl.sv
module mab_block_ctrl #(
  parameter int NC = 3,
  parameter int CW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NC-1:0]  set_ev,
  input  logic [NC-1:0]  clr_ev,
  output logic [NC-1:0]  mask,
  output logic           stall,
  output logic [NC*CW-1:0] cyc_flat
);
  logic [NC-1:0] mask_n, cleared, charge;
  logic [CW-1:0] now, start;
  logic          empties, fills;

  always_comb begin
    mask_n  = (mask & ~clr_ev) | set_ev;
    cleared = mask & ~mask_n;
    charge  = '0;
    for (int i = NC-1; i >= 0; i--)
      if (cleared[i]) begin
        charge    = '0;
        charge[i] = 1'b1;
      end
  end

  assign empties = (mask != '0) && (mask_n == '0);
  assign fills   = (mask == '0) && (mask_n != '0);
  assign stall   = |mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask  <= '0;
      now   <= '0;
      start <= '0;
    end else begin
      mask <= mask_n;
      now  <= now + 1'b1;
      if (fills) start <= now;
    end
  end

  for (genvar c = 0; c < NC; c++) begin : g_cnt
    logic [CW-1:0] cnt;
    always_ff @(posedge clk) begin
      if (!rst_n)                    cnt <= '0;
      else if (empties && charge[c]) cnt <= cnt + (now - start);
    end
    assign cyc_flat[c*CW +: CW] = cnt;
  end
endmodule

// File: rtl/mab_miss_limit.sv
module mab_miss_limit #(
  parameter int MW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [MW-1:0] load_val,
  input  logic          dec,
  output logic          done
);
  logic [MW-1:0] left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left <= '0;
      done <= 1'b0;
    end else if (load) begin
      left <= load_val;
      done <= 1'b0;
    end else if (dec && left != '0) begin
      left <= left - 1'b1;
      done <= (left == MW'(1));
    end else begin
      done <= 1'b0;
    end
  end
endmodule

// File: rtl/mab_alloc_top.sv
module mab_alloc_top import mab_pkg::*; #(
  parameter int AW         = 32,
  parameter int LW         = 8,
  parameter int TW         = 16,
  parameter int OW         = 16,
  parameter int CW         = 16,
  parameter int MW         = 16,
  parameter int MISS_DEPTH = 4,
  parameter int WBUF_DEPTH = 2,
  parameter int BLK_BYTES  = 64,
  localparam int MAXD  = (MISS_DEPTH > WBUF_DEPTH) ? MISS_DEPTH : WBUF_DEPTH,
  localparam int SLOTW = (MAXD > 1) ? $clog2(MAXD) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_kind,
  input  logic [AW-1:0]    req_addr,
  input  logic [LW-1:0]    req_size,
  input  logic             req_bus,
  input  logic [TW-1:0]    req_ready_at,
  output logic             alloc_ok,
  output logic             alloc_pool,
  output logic [SLOTW-1:0] alloc_slot,
  output logic [AW-1:0]    alloc_addr,
  output logic [LW-1:0]    alloc_len,
  output logic [OW-1:0]    alloc_order,
  input  logic             svc_valid,
  input  logic             svc_pool,
  input  logic [SLOTW-1:0] svc_slot,
  output logic             svc_hit,
  output logic [AW-1:0]    svc_addr,
  output logic [LW-1:0]    svc_len,
  output logic [OW-1:0]    svc_order,
  input  logic             tgt_block,
  input  logic             tgt_unblock,
  output logic             stall,
  output logic [2:0]       blk_mask,
  output logic [3*CW-1:0]  blk_cycles,
  output logic [1:0]       bus_req,
  output logic [TW-1:0]    next_ready,
  input  logic             miss_load,
  input  logic [MW-1:0]    miss_load_val,
  output logic             miss_limit_hit
);
  // Block size must be a power of two for the mask-based alignment.
  localparam logic [AW-1:0] BLK_OFS = AW'(BLK_BYTES - 1);

  function automatic logic [AW-1:0] blk_align(input logic [AW-1:0] a);
    return a & ~BLK_OFS;
  endfunction

  function automatic logic [TW-1:0] tmin(input logic [TW-1:0] a, input logic [TW-1:0] b);
    return (a < b) ? a : b;
  endfunction

  logic                 pool_sel;
  logic [NUM_POOL-1:0]  p_fire, p_mark, p_can, p_hit, p_full, p_set, p_clr;
  logic [SLOTW-1:0]     p_slot  [NUM_POOL];
  logic [AW-1:0]        p_maddr [NUM_POOL];
  logic [LW-1:0]        p_mlen  [NUM_POOL];
  logic [OW-1:0]        p_mord  [NUM_POOL];
  logic [TW-1:0]        p_early [NUM_POOL];
  logic [NUM_CAUSE-1:0] set_ev, clr_ev;
  logic [OW-1:0]        order_q;
  logic                 miss_taken;

  assign pool_sel   = kind_to_pool(req_kind);
  assign alloc_ok   = req_valid && kind_legal(req_kind) && p_can[pool_sel];
  assign alloc_pool = pool_sel;
  assign alloc_slot = p_slot[pool_sel];
  assign alloc_addr = (req_kind == KIND_CMISS) ? blk_align(req_addr) : req_addr;
  assign alloc_len  = (req_kind == KIND_CMISS) ? LW'(BLK_BYTES) : req_size;
  assign alloc_order = order_q;
  assign miss_taken = alloc_ok && kind_is_miss(req_kind);

  for (genvar gp = 0; gp < NUM_POOL; gp++) begin : g_pool
    localparam int D = (gp == 0) ? MISS_DEPTH : WBUF_DEPTH;
    assign p_fire[gp] = alloc_ok && (pool_sel == gp[0]);
    assign p_mark[gp] = svc_valid && (svc_pool == gp[0]);

    mab_pool #(.DEPTH(D), .AW(AW), .LW(LW), .TW(TW), .OW(OW), .SLOTW(SLOTW)) u_pool (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc_fire (p_fire[gp]),
      .alloc_addr (alloc_addr),
      .alloc_len  (alloc_len),
      .alloc_ready(req_ready_at),
      .alloc_order(order_q),
      .mark_req   (p_mark[gp]),
      .mark_slot  (svc_slot),
      .can_alloc  (p_can[gp]),
      .free_slot  (p_slot[gp]),
      .mark_hit   (p_hit[gp]),
      .mark_addr  (p_maddr[gp]),
      .mark_len   (p_mlen[gp]),
      .mark_order (p_mord[gp]),
      .earliest   (p_early[gp]),
      .is_full    (p_full[gp]),
      .ev_set     (p_set[gp]),
      .ev_clr     (p_clr[gp])
    );
  end

  assign svc_hit    = p_hit[svc_pool];
  assign svc_addr   = p_maddr[svc_pool];
  assign svc_len    = p_mlen[svc_pool];
  assign svc_order  = p_mord[svc_pool];
  assign next_ready = tmin(p_early[0], p_early[1]);

  // The pool index doubles as the cause code.
  assign set_ev = {tgt_block,   p_set};
  assign clr_ev = {tgt_unblock, p_clr};

  mab_block_ctrl #(.NC(NUM_CAUSE), .CW(CW)) u_blk (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_ev  (set_ev),
    .clr_ev  (clr_ev),
    .mask    (blk_mask),
    .stall   (stall),
    .cyc_flat(blk_cycles)
  );

  mab_miss_limit #(.MW(MW)) u_lim (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (miss_load),
    .load_val(miss_load_val),
    .dec     (miss_taken),
    .done    (miss_limit_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      order_q <= '0;
      bus_req <= '0;
    end else begin
      if (alloc_ok) order_q <= order_q + 1'b1;
      bus_req <= {p_fire[1] && req_bus, p_fire[0] && req_bus};
    end
  end
endmodule

// File: rtl/mab_alloc_chk.sv
module mab_alloc_chk #(
  parameter int AW        = 32,
  parameter int LW        = 8,
  parameter int OW        = 16,
  parameter int BLK_BYTES = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          alloc_ok,
  input logic          alloc_pool,
  input logic [1:0]    req_kind,
  input logic          req_bus,
  input logic [AW-1:0] alloc_addr,
  input logic [LW-1:0] alloc_len,
  input logic [OW-1:0] alloc_order,
  input logic          stall,
  input logic [2:0]    blk_mask,
  input logic [1:0]    bus_req,
  input logic [2:0]    set_ev,
  input logic [1:0]    pool_full,
  input logic [1:0]    pool_hit,
  input logic [1:0]    pool_clr
);
  a_r1_write_pool: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_ok && req_kind == 2'd2 |-> alloc_pool);

  a_r1_bad_kind: assert property (@(posedge clk) disable iff (!rst_n)
    req_kind == 2'd3 |-> !alloc_ok);

  a_r2_block_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_ok && req_kind == 2'd0 |->
      ((alloc_addr & AW'(BLK_BYTES-1)) == '0) && alloc_len == LW'(BLK_BYTES));

  a_r4_order_step: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_ok |=> alloc_order == $past(alloc_order) + 1'b1);

  a_r5_no_grant_full0: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_ok && !alloc_pool && pool_full[0] |-> pool_hit[0]);

  a_r5_no_grant_full1: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_ok && alloc_pool && pool_full[1] |-> pool_hit[1]);

  a_r7_clear_needs_mark0: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(blk_mask[0]) |-> $past(pool_clr[0]));

  a_r7_clear_needs_mark1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(blk_mask[1]) |-> $past(pool_clr[1]));

  a_r8_stall_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall) |-> $past(set_ev != 3'd0));

  a_r10_bus_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_ok && req_bus |=> $countones(bus_req) == 1);

  a_r10_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !alloc_ok |=> bus_req == 2'b00);
endmodule

bind mab_alloc_top mab_alloc_chk #(.AW(AW), .LW(LW), .OW(OW), .BLK_BYTES(BLK_BYTES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .alloc_ok   (alloc_ok),
  .alloc_pool (alloc_pool),
  .req_kind   (req_kind),
  .req_bus    (req_bus),
  .alloc_addr (alloc_addr),
  .alloc_len  (alloc_len),
  .alloc_order(alloc_order),
  .stall      (stall),
  .blk_mask   (blk_mask),
  .bus_req    (bus_req),
  .set_ev     (set_ev),
  .pool_full  (p_full),
  .pool_hit   (p_hit),
  .pool_clr   (p_clr)
);

// File: tb/mab_alloc_top_test.sv
module mab_alloc_top_test;
  localparam int BLK = 64;
  localparam int D0 = 4, D1 = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_bus = 0, svc_valid = 0, svc_pool = 0;
  logic [1:0] req_kind = 0, svc_slot = 0;
  logic [31:0] req_addr = 0;
  logic [7:0] req_size = 0;
  logic [15:0] req_ready_at = 0, miss_load_val = 0;
  logic tgt_block = 0, tgt_unblock = 0, miss_load = 0;
  logic alloc_ok, alloc_pool, svc_hit, stall, miss_limit_hit;
  logic [1:0] alloc_slot, bus_req;
  logic [31:0] alloc_addr, svc_addr;
  logic [7:0] alloc_len, svc_len;
  logic [15:0] alloc_order, svc_order, next_ready;
  logic [2:0] blk_mask;
  logic [47:0] blk_cycles;

  always #4 clk = ~clk;

  mab_alloc_top uut (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  bit          mv   [2][4];
  logic [31:0] ma   [2][4];
  logic [7:0]  ml   [2][4];
  logic [15:0] mo   [2][4];
  logic [15:0] mr   [2][4];
  logic [2:0]  m_mask = 0;
  logic [15:0] m_cyc [3] = '{0, 0, 0};
  logic [15:0] m_now = 0, m_start = 0, m_order = 0, m_left = 0;
  logic [1:0]  m_bus = 0;
  logic        m_hit = 0;

  function automatic int dep(int p);
    return p ? D1 : D0;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_regs();
    chk("R8 stall", stall, m_mask != 0);
    chk("R6 R7 R13 mask", blk_mask, m_mask);
    chk("R9 cycles c0", blk_cycles[15:0], m_cyc[0]);
    chk("R9 cycles c1", blk_cycles[31:16], m_cyc[1]);
    chk("R9 cycles c2", blk_cycles[47:32], m_cyc[2]);
    chk("R10 bus_req", bus_req, m_bus);
    chk("R12 miss hit", miss_limit_hit, m_hit);
    chk("R4 order", alloc_order, m_order);
  endtask

  task automatic step(bit rv, logic [1:0] k, logic [31:0] a, logic [7:0] sz, bit bus,
                      logic [15:0] rdy, bit sv, bit sp, logic [1:0] ss,
                      bit tb, bit tu, bit ld, logic [15:0] lv);
    bit eff [2][4];
    bit fb [2], fa [2], mh, eok, found;
    int psel, slot;
    logic [15:0] er;
    logic [31:0] eaddr;
    logic [7:0] elen;
    logic [2:0] setv, clrv, nmask, cl;
    @(negedge clk);
    check_regs();
    req_valid = rv; req_kind = k; req_addr = a; req_size = sz; req_bus = bus;
    req_ready_at = rdy; svc_valid = sv; svc_pool = sp; svc_slot = ss;
    tgt_block = tb; tgt_unblock = tu; miss_load = ld; miss_load_val = lv;
    #1;
    er = 16'hffff;
    for (int p = 0; p < 2; p++)
      for (int i = 0; i < dep(p); i++) if (mv[p][i] && mr[p][i] < er) er = mr[p][i];
    chk("R11 next_ready", next_ready, er);
    mh = sv && (int'(ss) < dep(sp)) && mv[sp][ss];
    for (int p = 0; p < 2; p++)
      for (int i = 0; i < 4; i++) eff[p][i] = mv[p][i] && !(mh && sp == p && ss == i);
    chk("R7 svc_hit", svc_hit, mh);
    if (mh) begin
      chk("R4 svc_order", svc_order, mo[sp][ss]);
      chk("R2 R3 svc_addr", svc_addr, ma[sp][ss]);
      chk("R2 R3 svc_len", svc_len, ml[sp][ss]);
    end
    psel = (k == 2'd2);
    found = 0; slot = 0;
    for (int i = dep(psel) - 1; i >= 0; i--) if (!eff[psel][i]) begin found = 1; slot = i; end
    eok = rv && (k != 2'd3) && found;
    eaddr = (k == 2'd0) ? (a & ~32'(BLK - 1)) : a;
    elen  = (k == 2'd0) ? 8'(BLK) : sz;
    chk("R1 R5 alloc_ok", alloc_ok, eok);
    if (eok) begin
      chk("R1 alloc_pool", alloc_pool, psel);
      chk("R5 alloc_slot", alloc_slot, slot);
      chk(k == 2'd0 ? "R2 alloc_addr" : "R3 alloc_addr", alloc_addr, eaddr);
      chk(k == 2'd0 ? "R2 alloc_len" : "R3 alloc_len", alloc_len, elen);
    end
    // advance model to the next edge
    for (int p = 0; p < 2; p++) begin
      fb[p] = 1;
      for (int i = 0; i < dep(p); i++) if (!mv[p][i]) fb[p] = 0;
    end
    if (mh) mv[sp][ss] = 0;
    if (eok) begin
      mv[psel][slot] = 1; ma[psel][slot] = eaddr; ml[psel][slot] = elen;
      mo[psel][slot] = m_order; mr[psel][slot] = rdy;
    end
    for (int p = 0; p < 2; p++) begin
      fa[p] = 1;
      for (int i = 0; i < dep(p); i++) if (!mv[p][i]) fa[p] = 0;
    end
    setv = {tb, eok && psel == 1 && fa[1], eok && psel == 0 && fa[0]};
    clrv = {tu, mh && sp == 1 && fb[1], mh && sp == 0 && fb[0]};
    nmask = (m_mask & ~clrv) | setv;
    cl = m_mask & ~nmask;
    if (m_mask != 0 && nmask == 0) begin
      if (cl[0]) m_cyc[0] = m_cyc[0] + (m_now - m_start);
      else if (cl[1]) m_cyc[1] = m_cyc[1] + (m_now - m_start);
      else m_cyc[2] = m_cyc[2] + (m_now - m_start);
    end
    if (m_mask == 0 && nmask != 0) m_start = m_now;
    m_mask = nmask;
    m_now++;
    m_bus = {eok && bus && psel == 1, eok && bus && psel == 0};
    m_hit = 0;
    if (ld) m_left = lv;
    else if (eok && k != 2'd2 && m_left != 0) begin
      m_hit = (m_left == 1);
      m_left--;
    end
    if (eok) m_order++;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < 2; p++) for (int i = 0; i < 4; i++) mv[p][i] = 0;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // reset state
    chk("R11 reset next_ready", next_ready, 16'hffff);
    chk("R8 reset stall", stall, 0);
    // R1: illegal kind is ignored
    step(1, 2'd3, 32'h100, 8'd4, 1, 16'h10, 0, 0, 0, 0, 0, 0, 0);
    idle();
    // R12: load miss limit of 3
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 16'd3);
    // R2 R5 R6: fill pool 0 with cacheable misses, the 4th sets cause 0
    for (int i = 0; i < 4; i++)
      step(1, 2'd0, 32'h1000 + 32'(i * 70 + 5), 8'd3, 1, 16'(100 - i), 0, 0, 0, 0, 0, 0, 0);
    // R5: full pool refuses
    step(1, 2'd1, 32'h2003, 8'd2, 0, 16'h5, 0, 0, 0, 0, 0, 0, 0);
    // R5 R7: mark + allocate on full pool in one cycle, bit stays
    step(1, 2'd1, 32'h3001, 8'd7, 0, 16'h50, 1, 0, 2'd1, 0, 0, 0, 0);
    idle();
    // R13: target cause set while pool cause set
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    // R7: mark of pool 1 free slot has no effect
    step(0, 0, 0, 0, 0, 0, 1, 1, 2'd0, 0, 0, 0, 0);
    // R7: mark from full clears cause 0
    step(0, 0, 0, 0, 0, 0, 1, 0, 2'd3, 0, 0, 0, 0);
    // R7: further mark of not-full pool changes nothing
    step(0, 0, 0, 0, 0, 0, 1, 0, 2'd0, 0, 0, 0, 0);
    // R9 R13: clear target -> charged to cause 2
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    // R13: set and clear together, set wins
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    // R3 R10: writes fill pool 1
    step(1, 2'd2, 32'h4007, 8'd9, 1, 16'h3, 0, 0, 0, 0, 0, 0, 0);
    step(1, 2'd2, 32'h4011, 8'd1, 1, 16'h9, 0, 0, 0, 0, 0, 0, 0);
    idle();
    step(0, 0, 0, 0, 0, 0, 1, 1, 2'd1, 0, 0, 0, 0);
    idle();
    // random traffic
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom_range(0, 99);
      step(r < 65, 2'($urandom_range(0, 3)), $urandom(), 8'($urandom()), ($urandom_range(0, 1) == 1),
           16'($urandom()), r > 40, ($urandom_range(0, 1) == 1), 2'($urandom_range(0, 3)),
           $urandom_range(0, 40) == 0, $urandom_range(0, 20) == 0,
           $urandom_range(0, 150) == 0, 16'($urandom_range(0, 6)));
    end
    idle();
    idle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule